// File: doc/BRIEF.md
# Addressed Backlog Counter Bank

This block keeps a bank of pending-work counters, one per priority level for each of a configurable number of group or crowd targets. Software reaches a counter through a memory-mapped page: the page number in the address picks the target, and bits inside the page offset pick both the priority and what to do to the counter. Three actions exist: add, subtract (clamped at zero), and a plain read.

A 2-byte load carries out the encoded action with a step of one and returns the count as it stood before the action. A 1-byte store carries out the action using the stored byte as the step and returns no data. Accesses of the wrong width, and accesses to a page past the last configured target, leave every counter as it is and raise the error flag. Each request is answered one clock later. The counter update lands on the same edge, so the next request already sees it.

Top module: `bkl_counter_bank`

## Requirements
- R1: The target is `req_addr[ADDR_W-1:PAGE_SHIFT]`, the priority is `req_addr[6:4]`, and every (target, priority) pair has its own counter. All other offset bits are ignored.
- R2: `req_addr[11:10]` selects the action: 2'b00 adds the step, 2'b01 subtracts it, and 2'b10 or 2'b11 only read, leaving the counter unchanged.
- R3: Every request with `req_valid` high gets `rsp_valid` high on the next cycle. `rsp_valid` and `rsp_err` stay low when there was no request.
- R4: A load (`req_write`=0) with `req_size`=1 (2 bytes) uses a step of 1 and returns in `rsp_rdata` the count from before the action, with `rsp_err` low.
- R5: A store (`req_write`=1) with `req_size`=0 (1 byte) uses `req_wdata` as the step. It returns `rsp_rdata`=0 with `rsp_err` low.
- R6: A subtraction whose step is equal to or greater than the count leaves the count at zero.
- R7: An addition wraps modulo 2^16. 0xFFFF plus 1 gives 0.
- R8: A load whose `req_size` is not 1 returns 16'hFFFF with `rsp_err` high and changes no counter.
- R9: A store whose `req_size` is not 0 changes no counter, returns 0 and raises `rsp_err`.
- R10: An access to a target at or above NUM_TARGETS changes no counter and raises `rsp_err`. A load of this kind returns 16'hFFFF.
- R11: Requests on consecutive cycles to the same counter see each other's updates in order.
- R12: Synchronous active-low reset clears every counter to zero and holds `rsp_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for store, 0 for load |
| req_size | input | 2 | log2 of access bytes (0=1B, 1=2B, 2=4B, 3=8B) |
| req_addr | input | ADDR_W | Byte address within the bank |
| req_wdata | input | 8 | Store byte (step for stores) |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 16 | Old count, 0 for stores, all ones for a rejected load |
| rsp_err | output | 1 | Previous request was rejected |

## Verification
The assertions assume that the request inputs are stable and known whenever `req_valid` is high. They also assume that a new request may arrive on every cycle, with no back-pressure. The stimulus drives all request fields on the falling edge and holds them through the rising edge. It keeps them at defined values even when `req_valid` is low. Random traffic mixes legal and illegal sizes, out-of-range pages and random filler in the ignored offset bits. Directed sequences push counters into the clamp at zero and the wrap at 0xFFFF.

// File: rtl/bkl_pkg.sv
// Package: shared encodings for the backlog counter bank.
// Assumes the in-page offset layout is fixed: action in bits 11:10,
// priority in bits 6:4.
package bkl_pkg;
    localparam int NUM_PRIO = 8;
    localparam int PRIO_W   = 3;
    localparam int OP_LSB   = 10;
    localparam int PRIO_LSB = 4;
    localparam int CNT_W    = 16;

    typedef enum logic [1:0] {
        OP_ADD   = 2'b00,
        OP_SUB   = 2'b01,
        OP_PEEK0 = 2'b10,
        OP_PEEK1 = 2'b11
    } bkl_op_e;

    typedef enum logic [1:0] {
        SZ_B1 = 2'd0,
        SZ_B2 = 2'd1,
        SZ_B4 = 2'd2,
        SZ_B8 = 2'd3
    } bkl_size_e;
endpackage

// File: rtl/bkl_decode.sv
// Module: bkl_decode
// Splits a request address into target, priority and action. Also judges
// whether the request is legal: the width must suit its direction and the
// page must be a configured target.
// Assumes PAGE_SHIFT >= 12 so the offset fields sit inside one page.
module bkl_decode
    import bkl_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int PAGE_SHIFT  = 12,
    parameter int NUM_TARGETS = 16,
    localparam int PG_W       = ADDR_W - PAGE_SHIFT,
    localparam int TGT_W      = (NUM_TARGETS > 1) ? $clog2(NUM_TARGETS) : 1
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [TGT_W-1:0]  tgt_idx,
    output logic [PRIO_W-1:0] prio,
    output bkl_op_e           op,
    output logic              access_ok,
    output logic              access_err
);
    localparam logic [PG_W:0] TGT_LIMIT = (PG_W+1)'(NUM_TARGETS);

    logic [PG_W-1:0] page;
    logic            size_ok;
    logic            in_range;

    // Field extraction from the address.
    always_comb begin
        page    = req_addr[ADDR_W-1:PAGE_SHIFT];
        tgt_idx = page[TGT_W-1:0];
        prio    = req_addr[PRIO_LSB +: PRIO_W];
        op      = bkl_op_e'(req_addr[OP_LSB +: 2]);
    end

    // Legality: width per direction and page within the configured targets.
    always_comb begin
        size_ok    = req_write ? (req_size == SZ_B1) : (req_size == SZ_B2);
        in_range   = {1'b0, page} < TGT_LIMIT;
        access_ok  = req_valid && size_ok && in_range;
        access_err = req_valid && !(size_ok && in_range);
    end
endmodule

// File: rtl/bkl_update.sv
// Module: bkl_update
// Works out the next count for one access: add with wrap, subtract clamped
// at zero, or unchanged for a peek. Purely combinational.
module bkl_update
    import bkl_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  bkl_op_e      op,
    input  logic [W-1:0] old_cnt,
    input  logic [W-1:0] step,
    output logic [W-1:0] new_cnt,
    output logic         changes
);
    // Next-value selection per action.
    always_comb begin
        unique case (op)
            OP_ADD:  new_cnt = old_cnt + step;
            OP_SUB:  new_cnt = (old_cnt > step) ? (old_cnt - step) : '0;
            default: new_cnt = old_cnt;
        endcase
        changes = (op == OP_ADD) || (op == OP_SUB);
    end

    // Guards on the arithmetic result.
    always_comb begin
        if (op == OP_SUB) begin
            a_r6_sub_never_grows: assert (new_cnt <= old_cnt);
        end
        if (!changes) begin
            a_r2_peek_keeps_value: assert (new_cnt == old_cnt);
        end
    end
endmodule

// File: rtl/bkl_store.sv
// Module: bkl_store
// Flat register store of all counters, indexed by {target, priority}.
// Provides one combinational read port and one write port.
// Assumes the write index is always that of a configured counter.
module bkl_store
    import bkl_pkg::*;
#(
    parameter int NUM_TARGETS = 16,
    parameter int W           = CNT_W,
    localparam int TGT_W      = (NUM_TARGETS > 1) ? $clog2(NUM_TARGETS) : 1,
    localparam int IDX_W      = TGT_W + PRIO_W,
    localparam int ENTRIES    = NUM_TARGETS * NUM_PRIO
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data
);
    logic [ENTRIES-1:0][W-1:0] cnt_q;

    // Counter storage: cleared on reset, one entry written per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_en) begin
            cnt_q[wr_idx] <= wr_data;
        end
    end

    // Read port.
    always_comb begin
        rd_data = cnt_q[rd_idx];
    end

    a_r2_stable_unless_written: assert property (
        @(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cnt_q));

    a_r11_write_lands: assert property (
        @(posedge clk) disable iff (!rst_n)
        wr_en |=> cnt_q[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/bkl_counter_bank.sv
// Module: bkl_counter_bank
// Top of the addressed backlog counter bank. Decodes each request, applies
// the action to the selected counter in the same cycle and registers a
// one-cycle-later response.
// Assumes at most one request per cycle with no back-pressure.
module bkl_counter_bank
    import bkl_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int PAGE_SHIFT  = 12,
    parameter int NUM_TARGETS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_wdata,
    output logic              rsp_valid,
    output logic [15:0]       rsp_rdata,
    output logic              rsp_err
);
    localparam int TGT_W = (NUM_TARGETS > 1) ? $clog2(NUM_TARGETS) : 1;
    localparam int IDX_W = TGT_W + PRIO_W;

    logic [TGT_W-1:0]  tgt_idx;
    logic [PRIO_W-1:0] prio;
    bkl_op_e           op;
    logic              access_ok;
    logic              access_err;
    logic [IDX_W-1:0]  cnt_idx;
    logic [CNT_W-1:0]  old_cnt;
    logic [CNT_W-1:0]  new_cnt;
    logic [CNT_W-1:0]  step;
    logic              changes;
    logic              wr_en;

    bkl_decode #(
        .ADDR_W      (ADDR_W),
        .PAGE_SHIFT  (PAGE_SHIFT),
        .NUM_TARGETS (NUM_TARGETS)
    ) i_decode (
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_size   (req_size),
        .req_addr   (req_addr),
        .tgt_idx    (tgt_idx),
        .prio       (prio),
        .op         (op),
        .access_ok  (access_ok),
        .access_err (access_err)
    );

    // Counter index and step size for this access.
    always_comb begin
        cnt_idx = {tgt_idx, prio};
        step    = req_write ? {{(CNT_W-8){1'b0}}, req_wdata} : CNT_W'(1);
        wr_en   = access_ok && changes;
    end

    bkl_update #(.W(CNT_W)) i_update (
        .op      (op),
        .old_cnt (old_cnt),
        .step    (step),
        .new_cnt (new_cnt),
        .changes (changes)
    );

    bkl_store #(
        .NUM_TARGETS (NUM_TARGETS),
        .W           (CNT_W)
    ) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (cnt_idx),
        .rd_data (old_cnt),
        .wr_en   (wr_en),
        .wr_idx  (cnt_idx),
        .wr_data (new_cnt)
    );

    // Response register: old count on a good load, ones on a bad load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= access_err;
            if (!req_valid || req_write) begin
                rsp_rdata <= '0;
            end else if (access_ok) begin
                rsp_rdata <= old_cnt;
            end else begin
                rsp_rdata <= '1;
            end
        end
    end

    a_r3_rsp_follows_req: assert property (
        @(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r3_quiet_when_idle: assert property (
        @(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && !rsp_err);

    a_r5_store_returns_zero: assert property (
        @(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> rsp_rdata == 16'h0000);

    a_r10_bad_load_ones: assert property (
        @(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && access_err) |=> rsp_err && rsp_rdata == 16'hFFFF);

    a_r8_no_write_on_error: assert property (
        @(posedge clk) disable iff (!rst_n)
        access_err |-> !wr_en);
endmodule

// File: tb/test_bkl_counter_bank.sv
`timescale 1ns/100ps
module test_bkl_counter_bank;
    localparam int ADDR_W = 20;
    localparam int PSH    = 12;
    localparam int NT     = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [1:0]        req_size = 2'd0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [7:0]        req_wdata = '0;
    logic              rsp_valid;
    logic [15:0]       rsp_rdata;
    logic              rsp_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    int model [NT][8];

    always #2.5 clk = ~clk;

    bkl_counter_bank #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PSH), .NUM_TARGETS(NT)) i_bkl_counter_bank (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk_addr(int tgt, int op, int prio, int junk);
        logic [ADDR_W-1:0] a;
        a = ADDR_W'(tgt) << PSH;
        a[11:10] = 2'(op);
        a[6:4] = 3'(prio);
        a[3:0] = 4'(junk);
        a[9:7] = 3'(junk >> 4);
        return a;
    endfunction

    // Reference: expected data and error, updates the model.
    task automatic predict(input bit wr, input int sz, input int tgt, input int op,
                           input int prio, input int wd, output int ed, output bit ee);
        int step, old;
        bit ok;
        ok = (tgt < NT) && (wr ? (sz == 0) : (sz == 1));
        ee = !ok;
        ed = wr ? 0 : (ok ? model[tgt][prio] : 16'hFFFF);
        if (ok) begin
            old = model[tgt][prio];
            step = wr ? wd : 1;
            if (op == 0) model[tgt][prio] = (old + step) & 16'hFFFF;
            else if (op == 1) model[tgt][prio] = (old > step) ? old - step : 0;
        end
    endtask

    // One access: drive on falling edge, sample 1 ns after the next rising edge.
    task automatic access(input bit wr, input int sz, input int tgt, input int op,
                          input int prio, input int wd, input int junk, input string req);
        int ed;
        bit ee;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_size  = 2'(sz);
        req_addr  = mk_addr(tgt, op, prio, junk);
        req_wdata = 8'(wd);
        predict(wr, sz, tgt, op, prio, wd, ed, ee);
        @(posedge clk);
        #1;
        check(rsp_valid === 1'b1, {req, " R3 rsp_valid"}, int'(rsp_valid), 1);
        check(rsp_rdata === 16'(ed), {req, " data"}, int'(rsp_rdata), ed);
        check(rsp_err === ee, {req, " err"}, int'(rsp_err), int'(ee));
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk);
        #1;
        check(rsp_valid === 1'b0 && rsp_err === 1'b0, "R3 idle", int'({rsp_valid, rsp_err}), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0b1c));
        foreach (model[t, p]) model[t][p] = 0;
        repeat (3) @(posedge clk);
        #1;
        check(rsp_valid === 1'b0, "R12 rsp_valid in reset", int'(rsp_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R12: all counters read zero after reset (peek, no change).
        for (int t = 0; t < NT; t++)
            for (int p = 0; p < 8; p++)
                access(0, 1, t, 2, p, 0, 0, "R12 reset clear");
        idle();

        // R4/R11: back-to-back loads add one each, return old count.
        access(0, 1, 2, 0, 3, 0, 5, "R4 load add");
        access(0, 1, 2, 0, 3, 0, 9, "R11 back-to-back add");
        access(0, 1, 2, 3, 3, 0, 0, "R2 peek 11");
        access(0, 1, 2, 1, 3, 0, 0, "R4 load sub");
        // R1: neighbour priority and target untouched.
        access(0, 1, 2, 2, 2, 0, 0, "R1 other prio");
        access(0, 1, 3, 2, 3, 0, 0, "R1 other target");
        // R5/R6: store step and clamp at zero.
        access(1, 0, 4, 1, 5, 9, 0, "R6 sub below zero");
        access(0, 1, 4, 2, 5, 0, 0, "R6 stays zero");
        access(1, 0, 4, 0, 5, 9, 0, "R5 store add 9");
        access(1, 0, 4, 1, 5, 9, 0, "R6 sub equal");
        access(0, 1, 4, 2, 5, 0, 0, "R6 equal gives zero");
        access(1, 0, 4, 0, 5, 5, 0, "R5 store add 5");
        access(1, 0, 4, 1, 5, 200, 0, "R6 sub larger");
        access(0, 1, 4, 3, 5, 0, 0, "R6 clamp read");
        // R8/R9: bad sizes.
        access(1, 0, 6, 0, 1, 7, 0, "R9 setup");
        access(0, 0, 6, 0, 1, 0, 0, "R8 load size 1B");
        access(0, 3, 6, 1, 1, 0, 0, "R8 load size 8B");
        access(1, 1, 6, 0, 1, 50, 0, "R9 store size 2B");
        access(1, 2, 6, 1, 1, 50, 0, "R9 store size 4B");
        access(0, 1, 6, 2, 1, 0, 0, "R9 count unchanged");
        // R10: out-of-range targets.
        access(0, 1, NT, 0, 1, 0, 0, "R10 load out of range");
        access(1, 0, NT + 5, 0, 1, 3, 0, "R10 store out of range");
        access(0, 1, NT - 1, 2, 1, 0, 0, "R10 last target intact");
        // R7: wrap at 0xFFFF.
        for (int k = 0; k < 257; k++) access(1, 0, 3, 0, 7, 255, k, "R7 fill");
        access(0, 1, 3, 0, 7, 0, 0, "R7 wrap load");
        access(0, 1, 3, 2, 7, 0, 0, "R7 wrapped to zero");
        idle();

        // Random mix, checked against the model.
        for (int k = 0; k < 4000; k++) begin
            bit wr;
            int sz, tgt, op, prio, wd;
            wr = $urandom_range(1, 0);
            sz = ($urandom_range(9, 0) == 0) ? $urandom_range(3, 0) : (wr ? 0 : 1);
            tgt = $urandom_range(NT + 3, 0);
            op = $urandom_range(3, 0);
            prio = $urandom_range(7, 0);
            wd = $urandom_range(255, 0);
            access(wr, sz, tgt, op, prio, wd, $urandom_range(127, 0), "R1 R2 random");
            if ($urandom_range(15, 0) == 0) idle();
        end
        idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule